// File: doc/BRIEF.md
# Shared Peripheral Timebase Prescaler

This block generates the count-enable strobes for five peripherals that share one time base: three general timers, a counter array and a watchdog. A 4-bit down counter reloads from a programmable divide field whenever it reaches zero. The strobe it produces is therefore high for one system clock in every (field + 1) clocks, which gives a division of 1 to 16.

A mode input picks how the strobes are routed. In compatibility mode every peripheral counts on the divided strobe, whatever its select bit says. In fast mode each peripheral has its own select bit. A set bit routes the divided strobe to that peripheral. A clear bit lets the peripheral count on every system clock. After reset the counter starts from a divide value of 5, so by default peripherals count once every six clocks.

Top module: `tbp_timebase`

## Requirements
- R1: While the internal counter is nonzero, it decreases by exactly one on each rising clock edge.
- R2: On the rising edge where the counter is zero, it loads the value present on `div_i`. A change to `div_i` therefore takes effect only at the next reload.
- R3: The divided strobe is high for exactly one clock in every (`div_i` + 1) clocks when `div_i` is held. With `div_i` = 0 it is high on every clock, and with `div_i` = 15 it is high once every 16 clocks.
- R4: Reset sets the counter to 5. The first divided strobe appears after the fifth rising edge following reset release, and with `div_i` = 5 it then repeats every six clocks.
- R5: With `compat_i` = 1, all five bits of `cnt_en_o` equal the divided strobe, regardless of `use_pre_i`.
- R6: With `compat_i` = 0, bit p of `cnt_en_o` equals the divided strobe when `use_pre_i[p]` = 1 and is 1 on every clock when `use_pre_i[p]` = 0. Bit p maps as follows: bits 0 to 2 are timers 0 to 2, bit 3 is the counter array, and bit 4 is the watchdog.
- R7: While `rst_ni` is low, every bit of `cnt_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 4 | Divide field; ratio is value + 1 |
| compat_i | input | 1 | 1 = compatibility mode, 0 = fast mode |
| use_pre_i | input | 5 | Per-peripheral prescaler select, used in fast mode |
| cnt_en_o | output | 5 | Per-peripheral count-enable strobe |

## Verification
Four behaviours are asserted on every cycle: the counter steps down by one, it reloads from the divide field at zero, the strobes follow the divided tick in compatibility mode, and unselected peripherals are held high in fast mode. Other properties can only be shown by the bench's scenarios, which run against a behavioural counter model. These are the first-strobe position after reset, the exact periods at divide values 0 and 15, the deferred effect of a mid-count divide change, and the outputs held low during reset.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
    localparam int unsigned TBP_CW      = 4;
    localparam int unsigned TBP_NPER    = 5;
    localparam int unsigned TBP_RST_DIV = 5;

    typedef struct packed {
        logic [TBP_CW-1:0] cnt;
    } tbp_div_state_t;
endpackage

// File: rtl/tbp_divider.sv
module tbp_divider
    import tbp_pkg::*;
#(
    parameter int unsigned CW      = TBP_CW,
    parameter int unsigned RST_DIV = TBP_RST_DIV
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] div_i,
    output logic          tick_o
);
    localparam logic [CW-1:0] CNT_ZERO  = '0;
    localparam logic [CW-1:0] CNT_START = CW'(RST_DIV);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_zero;

    always_comb begin
        at_zero = (cnt_q == CNT_ZERO);
        cnt_d   = cnt_q;
        if (at_zero) begin
            cnt_d = div_i;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
        tick_o = at_zero;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= CNT_START;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
    AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_ZERO) |=> (cnt_q == $past(div_i))); // R2
endmodule

// File: rtl/tbp_route.sv
module tbp_route #(
    parameter int unsigned NPER = tbp_pkg::TBP_NPER
) (
    input  logic            run_i,
    input  logic            tick_i,
    input  logic            force_i,
    input  logic [NPER-1:0] sel_i,
    output logic [NPER-1:0] en_o
);
    for (genvar p = 0; p < NPER; p++) begin : g_per
        logic use_div;
        always_comb begin
            use_div = force_i | sel_i[p];
            if (!run_i) begin
                en_o[p] = 1'b0;
            end else if (use_div) begin
                en_o[p] = tick_i;
            end else begin
                en_o[p] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tbp_timebase.sv
module tbp_timebase
    import tbp_pkg::*;
#(
    parameter int unsigned CW      = TBP_CW,
    parameter int unsigned NPER    = TBP_NPER,
    parameter int unsigned RST_DIV = TBP_RST_DIV
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [CW-1:0]   div_i,
    input  logic            compat_i,
    input  logic [NPER-1:0] use_pre_i,
    output logic [NPER-1:0] cnt_en_o
);
    localparam logic [NPER-1:0] ALL_ONE = '1;

    logic tick;

    tbp_divider #(.CW(CW), .RST_DIV(RST_DIV)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .div_i  (div_i),
        .tick_o (tick)
    );

    tbp_route #(.NPER(NPER)) u_route (
        .run_i   (rst_ni),
        .tick_i  (tick),
        .force_i (compat_i),
        .sel_i   (use_pre_i),
        .en_o    (cnt_en_o)
    );

    AST_COMPAT_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        compat_i |-> (cnt_en_o == (tick ? ALL_ONE : '0))); // R5
    AST_FAST_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !compat_i |-> ((cnt_en_o | use_pre_i) == ALL_ONE)); // R6
endmodule

// File: tb/sim_tbp_timebase.sv
module sim_tbp_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] div = 4'd5;
    logic       compat = 1'b1;
    logic [4:0] use_pre = 5'd0;
    logic [4:0] cnt_en;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 5;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tbp_timebase u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .div_i     (div),
        .compat_i  (compat),
        .use_pre_i (use_pre),
        .cnt_en_o  (cnt_en)
    );

    function automatic logic [4:0] expect_out(int c, logic cm, logic [4:0] sel);
        logic [4:0] r;
        logic t;
        t = (c == 0);
        for (int p = 0; p < 5; p++) r[p] = (cm || sel[p]) ? t : 1'b1;
        return r;
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: cnt_en actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one clock: drive inputs, model the edge, compare at the next falling edge
    task automatic step(string tag, logic [3:0] d, logic cm, logic [4:0] sel);
        div = d; compat = cm; use_pre = sel;
        @(negedge clk);
        m_cnt = (m_cnt == 0) ? int'(d) : m_cnt - 1;
        check(tag, cnt_en, expect_out(m_cnt, cm, sel));
    endtask

    initial begin
        int gap;
        repeat (3) begin
            @(negedge clk);
            check("R7", cnt_en, 5'b00000);
        end
        rst_n = 1'b1;
        m_cnt = 5;
        // R4: first strobe after the fifth rising edge
        gap = 0;
        for (int i = 0; i < 8; i++) begin
            step("R4", 4'd5, 1'b1, 5'b10101);
            gap++;
            if (cnt_en[0]) break;
        end
        check("R4", 5'(gap), 5'd5);
        for (int i = 0; i < 18; i++) step("R4", 4'd5, 1'b1, 5'b01010);
        // R5: compatibility mode ignores selects
        for (int i = 0; i < 40; i++) step("R5", 4'd3, 1'b1, 5'(i * 7));
        // R6: fast mode, no selects then mixed selects
        for (int i = 0; i < 20; i++) step("R6", 4'd2, 1'b0, 5'b00000);
        for (int i = 0; i < 40; i++) step("R6", 4'd4, 1'b0, 5'(i * 3 + 1));
        // R3: divide by one
        for (int i = 0; i < 20; i++) step("R3", 4'd0, 1'b0, 5'b11111);
        // R3: divide by sixteen, measured gap
        while (!cnt_en[0]) step("R3", 4'd15, 1'b1, 5'b00000);
        gap = 0;
        do begin
            step("R3", 4'd15, 1'b1, 5'b00000);
            gap++;
        end while (!cnt_en[0] && gap < 40);
        check("R3", 5'(gap), 5'd16);
        // R2: divide change mid-count is deferred
        for (int i = 0; i < 5; i++) step("R2", 4'd9, 1'b1, 5'b00000);
        for (int i = 0; i < 30; i++) step("R2", 4'd1, 1'b1, 5'b00000);
        // R1: sweep of divide values
        for (int d = 0; d < 16; d++)
            for (int i = 0; i < 20; i++) step("R1", 4'(d), 1'b0, 5'(d + i));
        // R7: reset asserted mid-run
        rst_n = 1'b0;
        #1;
        check("R7", cnt_en, 5'b00000);
        @(negedge clk);
        check("R7", cnt_en, 5'b00000);
        rst_n = 1'b1;
        m_cnt = 5;
        for (int i = 0; i < 12; i++) step("R4", 4'd5, 1'b0, 5'b11111);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule